// File: doc/BRIEF.md
# Overflow-Sampling Event Counter Bank

A bank of event counters that asks for a sample each time a counter has seen a programmed number of events. Software stores a period for each counter and issues a start command. Each active counter is then loaded with the 48-bit two's-complement negative of its period and counts up by one in every cycle where its event line is high and its enable bit is set. When bit 31 of an active counter reads 0, the interval is complete. The bank sets that counter's sticky status bit, raises the level sample request and reloads the counter with the negated period in the same edge.

A counter whose period is 0 is idle. Start, stop and the overflow check all pass over it, so software may use it as a free-running counter. A clear command parks every counter at all ones, which leaves no stale overflow behind. Control words hold reserved bits that software writes cannot alter. The 12-bit event select of each counter is driven out to the event decoder that feeds `event_i`.

The register port is a single write strobe with a combinational read. `reg_addr_i[4:3]` picks the kind of register: 0 is the counter value, 1 the control word, 2 the period and 3 a command. `reg_addr_i[2:0]` is the counter index. In the command space, index 0 is the command register on write and the status vector on read; index 1 is the status-clear register.

Top module: `ecb_bank`

## Requirements
- R1: After reset every counter reads 0x0000_FFFF_FFFF_FFFF, every control word reads 0x3000_0000, every period reads 0, the status vector is 0 and `sample_req_o` is low.
- R2: In each cycle where the counter's event input is high and its control enable bit (bit 22) is set, the counter increases by exactly one. In every other cycle without a write, a reload or an overflow, it holds its value.
- R3: A counter whose period is 0 never sets its status bit, even when its bit 31 is 0. A start command leaves its value and control word unchanged, and so does a stop command.
- R4: When an active counter has bit 31 equal to 0, the next edge does two things. It sets the counter's status bit, and it reloads the counter with the 48-bit negative of its period. No overflow is reported while bit 31 is 1.
- R5: A status bit stays set until a write to the status-clear register (kind 3, index 1) with data bit k set clears bit k. An overflow in the same cycle wins over the clear. `sample_req_o` is high while any status bit is set.
- R6: A counter write (kind 0) loads write data bits [31:0] sign-extended to 48 bits. A counter read returns the 48-bit value zero-extended to 64 bits.
- R7: A control write (kind 1) changes only the event select (bits [11:0]) and enable (bit 22) fields. All other bits keep their stored value. `evsel_o` slice k shows bits [11:0] of control word k.
- R8: Command bit 0 (start) loads each active counter with its negated period and sets its enable bit. Command bit 1 (stop) clears the enable bit of each active counter. When both bits are written together, the reload still happens and the enable ends cleared.
- R9: Command bit 2 (clear) sets every counter to all ones and zeroes the event select and enable fields of every control word. A start in the same write then applies to the active counters.
- R10: A period write (kind 2) stores write data bits [30:0]. Register writes to an index at or above NUM_CTR (4 or 6) have no effect, and register reads at such an index return 0. In the command space, any read at an index other than 0 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register kind [4:3] and counter index [2:0] |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 64 | Combinational read data for reg_addr_i |
| event_i | input | NUM_CTR | Per-counter event pulse |
| evsel_o | output | NUM_CTR*12 | Per-counter event select, counter k in slice k |
| sample_req_o | output | 1 | Level sample request |
| ovf_status_o | output | NUM_CTR | Sticky per-counter overflow status |

## Verification
The counting and reload assertions only cover cycles with no register write. They take for granted that software changes a period or counter value only through the port, and that it does not program a period that would make a reload land with bit 31 clear. The stimulus keeps every period at or below 2^31-1. It drives events only on counters whose state is fully known, and it applies every write and event at the falling edge, so each write lands in exactly one cycle. Overflow boundaries are reached by an exact count of event cycles. The bench checks the counter one event before the overflow point, at the zero point, and after the reload.

// File: rtl/ecb_pkg.sv
package ecb_pkg;
  localparam int CTR_W      = 48;
  localparam int EVSEL_W    = 12;
  localparam int CTL_W      = 32;
  localparam int PER_W      = 31;
  localparam int WDATA_W    = 32;
  localparam int RDATA_W    = 64;
  localparam int IDX_W      = 3;
  localparam int ADDR_W     = IDX_W + 2;
  localparam int EN_BIT     = 22;
  localparam int SAMPLE_BIT = 31;

  localparam logic [CTL_W-1:0] CTL_FIELDS = 32'h0040_0FFF;
  localparam logic [CTL_W-1:0] CTL_RESET  = 32'h3000_0000;

  localparam int CMD_START = 0;
  localparam int CMD_STOP  = 1;
  localparam int CMD_CLEAR = 2;

  typedef enum logic [1:0] {
    KIND_CNT = 2'd0,
    KIND_CTL = 2'd1,
    KIND_PER = 2'd2,
    KIND_CMD = 2'd3
  } reg_kind_e;

  function automatic logic [CTR_W-1:0] neg_period(input logic [PER_W-1:0] p);
    return ~{{(CTR_W-PER_W){1'b0}}, p} + CTR_W'(1);
  endfunction

  function automatic logic [CTR_W-1:0] sext_word(input logic [WDATA_W-1:0] w);
    return {{(CTR_W-WDATA_W){w[WDATA_W-1]}}, w};
  endfunction
endpackage

// File: rtl/ecb_counter.sv
module ecb_counter
  import ecb_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [WDATA_W-1:0] load_val_i,
  input  logic               start_i,
  input  logic               clear_i,
  input  logic               active_i,
  input  logic [PER_W-1:0]   period_i,
  input  logic               inc_i,
  output logic [CTR_W-1:0]   value_o,
  output logic               ovf_o
);
  logic [CTR_W-1:0] cnt_q, cnt_d;

  // overflow point: sample bit dropped to zero
  assign ovf_o   = active_i & ~cnt_q[SAMPLE_BIT];
  assign value_o = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)       cnt_d = sext_word(load_val_i);
    else if (start_i) cnt_d = neg_period(period_i);
    else if (clear_i) cnt_d = '1;
    else if (ovf_o)   cnt_d = neg_period(period_i);
    else if (inc_i)   cnt_d = cnt_q + CTR_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '1;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ecb_ctl_reg.sv
module ecb_ctl_reg
  import ecb_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [WDATA_W-1:0] wdata_i,
  input  logic               clear_i,
  input  logic               start_i,
  input  logic               stop_i,
  output logic [CTL_W-1:0]   ctl_o
);
  logic [CTL_W-1:0] ctl_q, ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_i)    ctl_d = (ctl_q & ~CTL_FIELDS) | (wdata_i & CTL_FIELDS);
    if (clear_i) ctl_d = ctl_d & ~CTL_FIELDS;
    if (start_i) ctl_d[EN_BIT] = 1'b1;
    if (stop_i)  ctl_d[EN_BIT] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= CTL_RESET;
    else         ctl_q <= ctl_d;
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/ecb_status.sv
module ecb_status #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] status_o
);
  logic [N-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= (st_q & ~clr_i) | set_i;
  end

  assign status_o = st_q;
endmodule

// File: rtl/ecb_bank.sv
module ecb_bank
  import ecb_pkg::*;
#(
  parameter int NUM_CTR = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       reg_we_i,
  input  logic [ADDR_W-1:0]          reg_addr_i,
  input  logic [WDATA_W-1:0]         reg_wdata_i,
  output logic [RDATA_W-1:0]         reg_rdata_o,
  input  logic [NUM_CTR-1:0]         event_i,
  output logic [NUM_CTR*EVSEL_W-1:0] evsel_o,
  output logic                       sample_req_o,
  output logic [NUM_CTR-1:0]         ovf_status_o
);
  localparam logic [IDX_W-1:0] STAT_IDX = IDX_W'(1);

  reg_kind_e              kind;
  logic [IDX_W-1:0]       idx;
  logic                   cmd_wr, stat_clr_wr;
  logic                   cmd_start, cmd_stop, cmd_clear;
  logic [NUM_CTR-1:0]     ovf_vec;
  logic [NUM_CTR-1:0]     stat_clr;

  logic [NUM_CTR-1:0][CTR_W-1:0] cnt_val;
  logic [NUM_CTR-1:0][CTL_W-1:0] ctl_val;
  logic [NUM_CTR-1:0][PER_W-1:0] per_q;

  assign kind        = reg_kind_e'(reg_addr_i[ADDR_W-1:IDX_W]);
  assign idx         = reg_addr_i[IDX_W-1:0];
  assign cmd_wr      = reg_we_i && kind == KIND_CMD && idx == '0;
  assign stat_clr_wr = reg_we_i && kind == KIND_CMD && idx == STAT_IDX;
  assign cmd_start   = cmd_wr & reg_wdata_i[CMD_START];
  assign cmd_stop    = cmd_wr & reg_wdata_i[CMD_STOP];
  assign cmd_clear   = cmd_wr & reg_wdata_i[CMD_CLEAR];
  assign stat_clr    = stat_clr_wr ? reg_wdata_i[NUM_CTR-1:0] : '0;

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
    logic hit, active;

    assign hit    = idx == IDX_W'(k);
    assign active = |per_q[k];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) per_q[k] <= '0;
      else if (reg_we_i && kind == KIND_PER && hit) per_q[k] <= reg_wdata_i[PER_W-1:0];
    end

    ecb_ctl_reg u_ctl (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (reg_we_i && kind == KIND_CTL && hit),
      .wdata_i (reg_wdata_i),
      .clear_i (cmd_clear),
      .start_i (cmd_start & active),
      .stop_i  (cmd_stop & active),
      .ctl_o   (ctl_val[k])
    );

    ecb_counter u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (reg_we_i && kind == KIND_CNT && hit),
      .load_val_i (reg_wdata_i),
      .start_i    (cmd_start & active),
      .clear_i    (cmd_clear),
      .active_i   (active),
      .period_i   (per_q[k]),
      .inc_i      (event_i[k] & ctl_val[k][EN_BIT]),
      .value_o    (cnt_val[k]),
      .ovf_o      (ovf_vec[k])
    );

    assign evsel_o[k*EVSEL_W +: EVSEL_W] = ctl_val[k][EVSEL_W-1:0];
  end

  ecb_status #(.N(NUM_CTR)) u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (ovf_vec),
    .clr_i    (stat_clr),
    .status_o (ovf_status_o)
  );

  assign sample_req_o = |ovf_status_o;

  always_comb begin
    reg_rdata_o = '0;
    for (int k = 0; k < NUM_CTR; k++) begin
      if (idx == IDX_W'(k)) begin
        unique case (kind)
          KIND_CNT: reg_rdata_o = {{(RDATA_W-CTR_W){1'b0}}, cnt_val[k]};
          KIND_CTL: reg_rdata_o = {{(RDATA_W-CTL_W){1'b0}}, ctl_val[k]};
          KIND_PER: reg_rdata_o = {{(RDATA_W-PER_W){1'b0}}, per_q[k]};
          default:  reg_rdata_o = '0;
        endcase
      end
    end
    if (kind == KIND_CMD && idx == '0)
      reg_rdata_o = {{(RDATA_W-NUM_CTR){1'b0}}, ovf_status_o};
  end
endmodule

// File: rtl/ecb_bank_chk.sv
module ecb_bank_chk
  import ecb_pkg::*;
#(
  parameter int NUM_CTR = 4
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          reg_we_i,
  input logic [ADDR_W-1:0]             reg_addr_i,
  input logic [WDATA_W-1:0]            reg_wdata_i,
  input logic [NUM_CTR-1:0]            event_i,
  input logic [NUM_CTR-1:0]            ovf_status_o,
  input logic [NUM_CTR-1:0][CTR_W-1:0] cnt_val,
  input logic [NUM_CTR-1:0][CTL_W-1:0] ctl_val,
  input logic [NUM_CTR-1:0][PER_W-1:0] per_q
);
  localparam logic [ADDR_W-1:0] CMD_ADDR  = {KIND_CMD, IDX_W'(0)};
  localparam logic [ADDR_W-1:0] STAT_ADDR = {KIND_CMD, IDX_W'(1)};

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_chk
    AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_status_o[k] && !(reg_we_i && reg_addr_i == STAT_ADDR && reg_wdata_i[k])
      |=> ovf_status_o[k]); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ovf_status_o[k]) |-> $past(per_q[k]) != '0); // R3

    AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !reg_we_i && per_q[k] != '0 && !cnt_val[k][SAMPLE_BIT]
      |=> cnt_val[k] == ~{{(CTR_W-PER_W){1'b0}}, $past(per_q[k])} + CTR_W'(1)
          && ovf_status_o[k]); // R4

    AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !reg_we_i && (per_q[k] == '0 || cnt_val[k][SAMPLE_BIT])
      && event_i[k] && ctl_val[k][EN_BIT]
      |=> cnt_val[k] == $past(cnt_val[k]) + CTR_W'(1)); // R2

    AST_COUNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !reg_we_i && (per_q[k] == '0 || cnt_val[k][SAMPLE_BIT])
      && !(event_i[k] && ctl_val[k][EN_BIT])
      |=> $stable(cnt_val[k])); // R2

    AST_RSVD_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (ctl_val[k] & ~CTL_FIELDS) == ($past(ctl_val[k]) & ~CTL_FIELDS)); // R7

    AST_STOP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      reg_we_i && reg_addr_i == CMD_ADDR && reg_wdata_i[CMD_STOP] && per_q[k] != '0
      |=> !ctl_val[k][EN_BIT]); // R8
  end
endmodule

bind ecb_bank ecb_bank_chk #(.NUM_CTR(NUM_CTR)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_we_i     (reg_we_i),
  .reg_addr_i   (reg_addr_i),
  .reg_wdata_i  (reg_wdata_i),
  .event_i      (event_i),
  .ovf_status_o (ovf_status_o),
  .cnt_val      (cnt_val),
  .ctl_val      (ctl_val),
  .per_q        (per_q)
);

// File: tb/sim_ecb_bank.sv
module sim_ecb_bank;
  localparam int N = 4;
  localparam logic [63:0] ALL1 = 64'h0000_FFFF_FFFF_FFFF;
  localparam logic [63:0] CRST = 64'h3000_0000;
  localparam logic [63:0] EN   = 64'h0040_0000;
  localparam logic [1:0]  K_CNT = 2'd0, K_CTL = 2'd1, K_PER = 2'd2, K_CMD = 2'd3;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          we = 1'b0;
  logic [4:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [63:0]   rdata;
  logic [N-1:0]  ev = '0;
  logic [N*12-1:0] evsel;
  logic          sreq;
  logic [N-1:0]  stat;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ecb_bank #(.NUM_CTR(N)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .event_i(ev), .evsel_o(evsel),
    .sample_req_o(sreq), .ovf_status_o(stat)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] kind, input int idx, input logic [31:0] d);
    we = 1'b1; addr = {kind, 3'(idx)}; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] kind, input int idx, output logic [63:0] d);
    addr = {kind, 3'(idx)};
    #1 d = rdata;
    @(negedge clk);
  endtask

  task automatic pulse(input logic [N-1:0] mask, input int n);
    ev = mask;
    repeat (n) @(negedge clk);
    ev = '0;
  endtask

  task automatic t_reset;
    logic [63:0] d;
    for (int k = 0; k < N; k++) begin
      rd(K_CNT, k, d); chk("R1 counter", d, ALL1);
      rd(K_CTL, k, d); chk("R1 control", d, CRST);
      rd(K_PER, k, d); chk("R1 period", d, 64'h0);
    end
    rd(K_CMD, 0, d); chk("R1 status", d, 64'h0);
    chk("R1 sample_req", 64'(sreq), 64'h0);
  endtask

  task automatic t_ctl_merge;
    logic [63:0] d;
    wr(K_CTL, 1, 32'hFFFF_FFFF);
    rd(K_CTL, 1, d); chk("R7 merge ones", d, 64'h3040_0FFF);
    chk("R7 evsel ones", 64'(evsel[23:12]), 64'hFFF);
    wr(K_CTL, 1, 32'h0000_0ABC);
    rd(K_CTL, 1, d); chk("R7 merge abc", d, 64'h3000_0ABC);
    chk("R7 evsel abc", 64'(evsel[23:12]), 64'hABC);
    wr(K_CTL, 1, 32'h0);
    rd(K_CTL, 1, d); chk("R7 merge zero", d, CRST);
  endtask

  task automatic t_count;
    logic [63:0] d;
    wr(K_CTL, 2, 32'h0040_0005);
    wr(K_CNT, 2, 32'h10);
    rd(K_CNT, 2, d); chk("R6 positive load", d, 64'h10);
    pulse(4'b0100, 5);
    rd(K_CNT, 2, d); chk("R2 five events", d, 64'h15);
    rd(K_CMD, 0, d); chk("R3 idle no status", d, 64'h0);
    wr(K_CTL, 2, 32'h0);
    pulse(4'b0100, 3);
    rd(K_CNT, 2, d); chk("R2 disabled holds", d, 64'h15);
  endtask

  task automatic t_sext;
    logic [63:0] d;
    wr(K_CNT, 3, 32'h8000_0001);
    rd(K_CNT, 3, d); chk("R6 negative sext", d, 64'h0000_FFFF_8000_0001);
    wr(K_CNT, 3, 32'h7FFF_FFFF);
    rd(K_CNT, 3, d); chk("R6 positive sext", d, 64'h7FFF_FFFF);
  endtask

  task automatic t_start_ovf;
    logic [63:0] d;
    wr(K_PER, 0, 32'd3);
    wr(K_CMD, 0, 32'b001);
    rd(K_CNT, 0, d); chk("R8 start load", d, 64'h0000_FFFF_FFFF_FFFD);
    rd(K_CTL, 0, d); chk("R8 start enable", d, CRST | EN);
    rd(K_CTL, 2, d); chk("R3 start skips idle ctl", d, CRST);
    rd(K_CNT, 2, d); chk("R3 start skips idle cnt", d, 64'h15);
    pulse(4'b0001, 2);
    rd(K_CNT, 0, d); chk("R4 one short", d, ALL1);
    rd(K_CMD, 0, d); chk("R4 no early status", d, 64'h0);
    pulse(4'b0001, 1);
    #1 chk("R4 zero point", rdata, 64'h0);
    addr = {K_CNT, 3'd0};
    #1 chk("R4 zero point count", rdata, 64'h0);
    @(negedge clk);
    rd(K_CMD, 0, d); chk("R4 status set", d, 64'h1);
    chk("R5 sample_req high", 64'(sreq), 64'h1);
    rd(K_CNT, 0, d); chk("R4 reload", d, 64'h0000_FFFF_FFFF_FFFD);
  endtask

  task automatic t_status;
    logic [63:0] d;
    repeat (5) @(negedge clk);
    rd(K_CMD, 0, d); chk("R5 sticky", d, 64'h1);
    wr(K_CMD, 1, 32'b10);
    rd(K_CMD, 0, d); chk("R5 other clear", d, 64'h1);
    wr(K_CMD, 1, 32'b01);
    rd(K_CMD, 0, d); chk("R5 cleared", d, 64'h0);
    chk("R5 sample_req low", 64'(sreq), 64'h0);
  endtask

  task automatic t_multi;
    logic [63:0] d;
    wr(K_PER, 0, 32'd2);
    wr(K_PER, 1, 32'd2);
    wr(K_CMD, 0, 32'b001);
    pulse(4'b0011, 2);
    @(negedge clk);
    rd(K_CMD, 0, d); chk("R4 two overflow", d, 64'h3);
    rd(K_CNT, 1, d); chk("R4 reload ctr1", d, 64'h0000_FFFF_FFFF_FFFE);
    wr(K_CMD, 1, 32'b11);
  endtask

  task automatic t_stop;
    logic [63:0] d;
    wr(K_CTL, 2, 32'h0040_0000);
    wr(K_CMD, 0, 32'b010);
    rd(K_CTL, 0, d); chk("R8 stop clears", d, CRST);
    rd(K_CTL, 2, d); chk("R3 stop skips idle", d, CRST | EN);
    pulse(4'b0001, 2);
    rd(K_CNT, 0, d); chk("R2 stopped holds", d, 64'h0000_FFFF_FFFF_FFFE);
    wr(K_CNT, 0, 32'h0000_0000 - 32'd1);
    wr(K_CMD, 0, 32'b011);
    rd(K_CNT, 0, d); chk("R8 start+stop reload", d, 64'h0000_FFFF_FFFF_FFFE);
    rd(K_CTL, 0, d); chk("R8 stop wins", d, CRST);
  endtask

  task automatic t_clear;
    logic [63:0] d;
    wr(K_CTL, 0, 32'h0040_0123);
    wr(K_CMD, 0, 32'b100);
    rd(K_CNT, 0, d); chk("R9 clear cnt0", d, ALL1);
    rd(K_CNT, 2, d); chk("R9 clear cnt2", d, ALL1);
    rd(K_CTL, 0, d); chk("R9 clear ctl0", d, CRST);
    rd(K_CTL, 2, d); chk("R9 clear ctl2", d, CRST);
    wr(K_CMD, 0, 32'b101);
    rd(K_CNT, 0, d); chk("R9 clear+start cnt0", d, 64'h0000_FFFF_FFFF_FFFE);
    rd(K_CTL, 0, d); chk("R9 clear+start ctl0", d, CRST | EN);
    rd(K_CNT, 2, d); chk("R9 clear+start idle", d, ALL1);
    rd(K_CMD, 0, d); chk("R9 no status", d, 64'h0);
  endtask

  task automatic t_index;
    logic [63:0] d;
    wr(K_PER, 3, 32'hFFFF_FFFF);
    rd(K_PER, 3, d); chk("R10 period width", d, 64'h7FFF_FFFF);
    wr(K_CNT, 5, 32'h1234);
    rd(K_CNT, 5, d); chk("R10 out of range read", d, 64'h0);
    rd(K_CNT, 0, d); chk("R10 ctr0 untouched", d, 64'h0000_FFFF_FFFF_FFFE);
    rd(K_CMD, 2, d); chk("R10 cmd index read", d, 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctl_merge();
    t_count();
    t_sext();
    t_start_ovf();
    t_status();
    t_multi();
    t_stop();
    t_clear();
    t_index();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule